// File: doc/BRIEF.md
# Conservative Load-Store Queue

This block keeps the memory operations of an out-of-order core in program order and decides when each one may touch data memory. Loads and stores are allocated in order and receive a queue tag. Address and data operands then arrive as separate events, carrying that tag. An entry forms its effective address as soon as its address operand arrives, whether or not its data has arrived.

Loads never run ahead of unresolved stores. A load waits until every older store in the queue has a known address. It then looks for the youngest older store to the same address. If that store already holds its data, the load takes the data directly. If the store's data is still missing, the load waits for it. If no older store matches, the load reads memory. Stores write memory only after they commit, in program order. One memory request or forward is started per cycle, and the oldest eligible entry wins.

Top module: `cons_lsq`

## Requirements
- R1: After reset `alloc_full` is 0, `alloc_tag` is 0, and neither `mreq_valid` nor `ldres_valid` is asserted.
- R2: Each accepted allocation takes tag `alloc_tag`, and the tags run 0, 1, …, DEPTH-1 and then wrap to 0. With DEPTH entries held, `alloc_full` is 1 and a further allocation is ignored, leaving `alloc_tag` unchanged.
- R3: An entry's effective address is `opa_base + opa_offset` modulo 2^AW. It is captured when the address event arrives, independently of the data operand, and any memory request for the entry carries it.
- R4: A load neither reads memory nor forwards while any older store in the queue has an unknown address, even when the addresses would differ.
- R5: When the youngest older store to the same address holds its data, the load result carries that store's data and no memory request is made for the load.
- R6: When that matching store lacks its data, no result is produced for the load until the data arrives; the store's data is then forwarded.
- R7: A store makes a write request (`mreq_write`=1, with its address and data and its tag) only after `commit_valid` has been given while it is the oldest entry and it holds both its address and its data. Stores leave the queue in program order.
- R8: At most one memory request or forward is started per cycle. When several loads become eligible in the same cycle, the oldest goes first and the next one follows in the next cycle.
- R9: Addresses are compared at their full width: addresses that differ only in bit AW-1 do not match.
- R10: A load's read request has `mreq_write`=0 and the load's tag. A `mrsp_valid` pulse with that tag yields `ldres_valid` with the same tag and data one clock later. No forward starts in a cycle that carries a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate the next entry in program order |
| alloc_is_store | input | 1 | 1: entry is a store, 0: a load |
| alloc_tag | output | IW | Tag the next allocation receives |
| alloc_full | output | 1 | All DEPTH entries in use |
| opa_valid | input | 1 | Address operand event |
| opa_tag | input | IW | Entry receiving the address operand |
| opa_base | input | AW | Address register value |
| opa_offset | input | AW | Immediate offset added to the base |
| opd_valid | input | 1 | Store data event |
| opd_tag | input | IW | Entry receiving the data |
| opd_value | input | DW | Store data value |
| commit_valid | input | 1 | Commit the oldest entry |
| mreq_valid | output | 1 | Memory request started |
| mreq_write | output | 1 | 1: write, 0: read |
| mreq_tag | output | IW | Entry making the request |
| mreq_addr | output | AW | Effective address |
| mreq_wdata | output | DW | Write data (0 for reads) |
| mrsp_valid | input | 1 | Read data returned |
| mrsp_tag | input | IW | Entry the read data belongs to |
| mrsp_data | input | DW | Read data |
| ldres_valid | output | 1 | Load result valid |
| ldres_tag | output | IW | Load tag of the result |
| ldres_data | output | DW | Load result data |

## Verification
The bench builds the queue with DEPTH=4 and 32-bit addresses and data. With DEPTH=4 the full condition can be reached in four allocations. The table of store/load pairs also walks the tags through several wraps of the circular order, so the age comparison is exercised across the wrap point. A 32-bit address lets a pair differing only in the top bit probe the full-width match.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  typedef enum logic [1:0] {
    LD_BLOCKED = 2'd0,
    LD_WAIT    = 2'd1,
    LD_FWD     = 2'd2,
    LD_READ    = 2'd3
  } ld_act_e;
endpackage

// File: rtl/lsq_age_scan.sv
// Per-entry walk over all older entries: finds unresolved stores and the
// youngest older store to the same address.
module lsq_age_scan
  import lsq_pkg::*;
#(
  parameter int DEPTH = 20,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic [IW-1:0]               head,
  input  logic [DEPTH-1:0]            v,
  input  logic [DEPTH-1:0]            st,
  input  logic [DEPTH-1:0]            aok,
  input  logic [DEPTH-1:0]            dok,
  input  logic [DEPTH-1:0][AW-1:0]    ea,
  input  logic [DEPTH-1:0][DW-1:0]    sd,
  output logic [DEPTH-1:0][1:0]       act,
  output logic [DEPTH-1:0][DW-1:0]    fwd
);
  localparam logic [IW:0] DEP = (IW+1)'(DEPTH);

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_scan
    logic          reached, blk, hit, hok;
    logic [DW-1:0] hd;
    logic [IW:0]   j;
    always_comb begin
      reached = 1'b0;
      blk     = 1'b0;
      hit     = 1'b0;
      hok     = 1'b0;
      hd      = '0;
      j       = '0;
      for (int k = 0; k < DEPTH; k++) begin
        j = {1'b0, head} + (IW+1)'(k);
        if (j >= DEP) j = j - DEP;
        if (j[IW-1:0] == IW'(gi)) begin
          reached = 1'b1;
        end else if (!reached && v[j[IW-1:0]] && st[j[IW-1:0]]) begin
          if (!aok[j[IW-1:0]]) begin
            blk = 1'b1;
          end else if (ea[j[IW-1:0]] == ea[gi]) begin
            hit = 1'b1;
            hok = dok[j[IW-1:0]];
            hd  = sd[j[IW-1:0]];
          end
        end
      end
      if (blk)              act[gi] = LD_BLOCKED;
      else if (hit && !hok) act[gi] = LD_WAIT;
      else if (hit)         act[gi] = LD_FWD;
      else                  act[gi] = LD_READ;
      fwd[gi] = hd;
    end
  end
endmodule

// File: rtl/lsq_pick.sv
// Oldest-first selection among eligible entries of the circular queue.
module lsq_pick #(
  parameter int DEPTH = 20,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic [IW-1:0]    head,
  input  logic [DEPTH-1:0] req,
  output logic             found,
  output logic [IW-1:0]    idx
);
  localparam logic [IW:0] DEP = (IW+1)'(DEPTH);
  logic [IW:0] j;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    j     = '0;
    for (int k = 0; k < DEPTH; k++) begin
      j = {1'b0, head} + (IW+1)'(k);
      if (j >= DEP) j = j - DEP;
      if (!found && req[j[IW-1:0]]) begin
        found = 1'b1;
        idx   = j[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/cons_lsq.sv
module cons_lsq
  import lsq_pkg::*;
#(
  parameter int DEPTH = 20,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_valid,
  input  logic          alloc_is_store,
  output logic [IW-1:0] alloc_tag,
  output logic          alloc_full,
  input  logic          opa_valid,
  input  logic [IW-1:0] opa_tag,
  input  logic [AW-1:0] opa_base,
  input  logic [AW-1:0] opa_offset,
  input  logic          opd_valid,
  input  logic [IW-1:0] opd_tag,
  input  logic [DW-1:0] opd_value,
  input  logic          commit_valid,
  output logic          mreq_valid,
  output logic          mreq_write,
  output logic [IW-1:0] mreq_tag,
  output logic [AW-1:0] mreq_addr,
  output logic [DW-1:0] mreq_wdata,
  input  logic          mrsp_valid,
  input  logic [IW-1:0] mrsp_tag,
  input  logic [DW-1:0] mrsp_data,
  output logic          ldres_valid,
  output logic [IW-1:0] ldres_tag,
  output logic [DW-1:0] ldres_data
);
  localparam logic [IW:0] DEP = (IW+1)'(DEPTH);

  // entry state
  logic [DEPTH-1:0]         v, st, aok, dok, iss, dne, cmt;
  logic [DEPTH-1:0][AW-1:0] ea;
  logic [DEPTH-1:0][DW-1:0] sd;
  logic [IW-1:0]            head, tail;
  logic [IW:0]              count;

  logic [DEPTH-1:0][1:0]    act;
  logic [DEPTH-1:0][DW-1:0] fwd;
  logic [DEPTH-1:0]         cand;
  logic                     pick_found;
  logic [IW-1:0]            pick_idx;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p);
    return ({1'b0, p} == DEP - 1'b1) ? '0 : p + 1'b1;
  endfunction

  function automatic logic in_range(input logic [IW-1:0] t);
    return {1'b0, t} < DEP;
  endfunction

  lsq_age_scan #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .IW(IW)) u_scan (
    .head(head), .v(v), .st(st), .aok(aok), .dok(dok),
    .ea(ea), .sd(sd), .act(act), .fwd(fwd)
  );

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      cand[i] = 1'b0;
      if (v[i]) begin
        if (st[i]) begin
          cand[i] = cmt[i] && (IW'(i) == head);
        end else begin
          cand[i] = aok[i] && !iss[i] &&
                    ((act[i] == LD_READ) || ((act[i] == LD_FWD) && !mrsp_valid));
        end
      end
    end
  end

  lsq_pick #(.DEPTH(DEPTH), .IW(IW)) u_pick (
    .head(head), .req(cand), .found(pick_found), .idx(pick_idx)
  );

  logic alloc_ok, commit_load, commit_store, write_go, deq;
  assign alloc_ok     = alloc_valid && (count != DEP);
  assign commit_load  = commit_valid && v[head] && !st[head] && dne[head];
  assign commit_store = commit_valid && v[head] && st[head] && aok[head] &&
                        dok[head] && !cmt[head];
  assign write_go     = pick_found && st[pick_idx];
  assign deq          = commit_load || write_go;

  assign alloc_tag  = tail;
  assign alloc_full = (count == DEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      v <= '0; st <= '0; aok <= '0; dok <= '0;
      iss <= '0; dne <= '0; cmt <= '0;
      ea <= '0; sd <= '0;
      head <= '0; tail <= '0; count <= '0;
      mreq_valid <= 1'b0; mreq_write <= 1'b0; mreq_tag <= '0;
      mreq_addr <= '0; mreq_wdata <= '0;
      ldres_valid <= 1'b0; ldres_tag <= '0; ldres_data <= '0;
    end else begin
      mreq_valid  <= 1'b0;
      ldres_valid <= 1'b0;

      if (opa_valid && in_range(opa_tag) && v[opa_tag]) begin
        ea[opa_tag]  <= opa_base + opa_offset;
        aok[opa_tag] <= 1'b1;
      end
      if (opd_valid && in_range(opd_tag) && v[opd_tag]) begin
        sd[opd_tag]  <= opd_value;
        dok[opd_tag] <= 1'b1;
      end

      if (mrsp_valid && in_range(mrsp_tag) && v[mrsp_tag]) begin
        dne[mrsp_tag] <= 1'b1;
        ldres_valid   <= 1'b1;
        ldres_tag     <= mrsp_tag;
        ldres_data    <= mrsp_data;
      end

      if (pick_found) begin
        if (st[pick_idx]) begin
          mreq_valid  <= 1'b1;
          mreq_write  <= 1'b1;
          mreq_tag    <= pick_idx;
          mreq_addr   <= ea[pick_idx];
          mreq_wdata  <= sd[pick_idx];
          v[pick_idx] <= 1'b0;
        end else if (act[pick_idx] == LD_READ) begin
          mreq_valid    <= 1'b1;
          mreq_write    <= 1'b0;
          mreq_tag      <= pick_idx;
          mreq_addr     <= ea[pick_idx];
          mreq_wdata    <= '0;
          iss[pick_idx] <= 1'b1;
        end else begin
          iss[pick_idx] <= 1'b1;
          dne[pick_idx] <= 1'b1;
          ldres_valid   <= 1'b1;
          ldres_tag     <= pick_idx;
          ldres_data    <= fwd[pick_idx];
        end
      end

      if (commit_load)  v[head]   <= 1'b0;
      if (commit_store) cmt[head] <= 1'b1;
      if (deq)          head      <= nxt(head);

      if (alloc_ok) begin
        v[tail]   <= 1'b1;
        st[tail]  <= alloc_is_store;
        aok[tail] <= 1'b0;
        dok[tail] <= 1'b0;
        iss[tail] <= 1'b0;
        dne[tail] <= 1'b0;
        cmt[tail] <= 1'b0;
        tail      <= nxt(tail);
      end

      count <= count + (IW+1)'(alloc_ok) - (IW+1)'(deq);
    end
  end
endmodule

// File: rtl/lsq_chk.sv
module lsq_chk #(
  parameter int DEPTH = 20,
  parameter int IW    = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             commit_valid,
  input logic [IW-1:0]    head,
  input logic [DEPTH-1:0] v,
  input logic [DEPTH-1:0] st,
  input logic [DEPTH-1:0] aok,
  input logic [DEPTH-1:0] dok,
  input logic [DEPTH-1:0] cmt,
  input logic [IW:0]      count,
  input logic [IW-1:0]    alloc_tag,
  input logic             alloc_full,
  input logic             mreq_valid,
  input logic             mreq_write,
  input logic [IW-1:0]    mreq_tag,
  input logic             ldres_valid,
  input logic [IW-1:0]    ldres_tag
);
  logic       head_unres;
  logic [IW:0] pend;
  assign head_unres = v[head] && st[head] && !aok[head];

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else pend <= pend
               + (IW+1)'(commit_valid && v[head] && st[head] && aok[head] && dok[head] && !cmt[head])
               - (IW+1)'(mreq_valid && mreq_write);
  end

  always @(posedge clk) begin
    if (!rst) begin
      assert_no_overflow_R2: assert (count <= (IW+1)'(DEPTH));
    end
  end

  assert_full_holds_tag_R2: assert property (@(posedge clk) disable iff (rst)
    alloc_full |=> alloc_tag == $past(alloc_tag));

  assert_read_not_past_unknown_R4: assert property (@(posedge clk) disable iff (rst)
    (mreq_valid && !mreq_write) |-> !$past(head_unres));

  assert_write_after_commit_R7: assert property (@(posedge clk) disable iff (rst)
    (mreq_valid && mreq_write) |-> pend != '0);

  assert_read_is_load_R10: assert property (@(posedge clk) disable iff (rst)
    (mreq_valid && !mreq_write) |-> (v[mreq_tag] && !st[mreq_tag]));

  assert_result_is_load_R5: assert property (@(posedge clk) disable iff (rst)
    ldres_valid |-> (v[ldres_tag] && !st[ldres_tag]));
endmodule

bind cons_lsq lsq_chk #(.DEPTH(DEPTH), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .commit_valid(commit_valid), .head(head),
  .v(v), .st(st), .aok(aok), .dok(dok), .cmt(cmt), .count(count),
  .alloc_tag(alloc_tag), .alloc_full(alloc_full),
  .mreq_valid(mreq_valid), .mreq_write(mreq_write), .mreq_tag(mreq_tag),
  .ldres_valid(ldres_valid), .ldres_tag(ldres_tag)
);

// File: tb/test_cons_lsq.sv
module test_cons_lsq;
  localparam int DEPTH = 4;
  localparam int IW    = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alloc_valid = 0, alloc_is_store = 0;
  logic [IW-1:0] alloc_tag;
  logic alloc_full;
  logic opa_valid = 0;
  logic [IW-1:0] opa_tag = '0;
  logic [31:0] opa_base = '0, opa_offset = '0;
  logic opd_valid = 0;
  logic [IW-1:0] opd_tag = '0;
  logic [31:0] opd_value = '0;
  logic commit_valid = 0;
  logic mreq_valid, mreq_write;
  logic [IW-1:0] mreq_tag;
  logic [31:0] mreq_addr, mreq_wdata;
  logic mrsp_valid = 0;
  logic [IW-1:0] mrsp_tag = '0;
  logic [31:0] mrsp_data = '0;
  logic ldres_valid;
  logic [IW-1:0] ldres_tag;
  logic [31:0] ldres_data;

  always #10 clk = ~clk;  // 50 MHz

  cons_lsq #(.DEPTH(DEPTH), .AW(32), .DW(32), .IW(IW)) i_cons_lsq (.*);

  function automatic logic [31:0] memval(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  // memory model: answer a read in the following cycle
  always @(negedge clk) begin
    if (mreq_valid && !mreq_write) begin
      mrsp_valid <= 1'b1; mrsp_tag <= mreq_tag; mrsp_data <= memval(mreq_addr);
    end else begin
      mrsp_valid <= 1'b0;
    end
  end

  // request / result logs
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  int mcnt = 0, lcnt = 0;
  logic        m_wr  [256];
  logic [31:0] m_addr[256], m_data[256];
  int          m_tag [256], m_cyc[256];
  int          l_tag [256];
  logic [31:0] l_data[256];
  always @(negedge clk) begin
    if (!rst && mreq_valid) begin
      m_wr[mcnt & 255] <= mreq_write; m_addr[mcnt & 255] <= mreq_addr;
      m_data[mcnt & 255] <= mreq_wdata; m_tag[mcnt & 255] <= int'(mreq_tag);
      m_cyc[mcnt & 255] <= cyc; mcnt <= mcnt + 1;
    end
    if (!rst && ldres_valid) begin
      l_tag[lcnt & 255] <= int'(ldres_tag); l_data[lcnt & 255] <= ldres_data;
      lcnt <= lcnt + 1;
    end
  end

  int nchk = 0, nfail = 0, ntag = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] a, input logic [31:0] e);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, a, e);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; step(2); rst = 1'b0; ntag = 0; step(1);
  endtask

  task automatic do_alloc(input bit s, output int t);
    t = ntag;
    alloc_valid = 1'b1; alloc_is_store = s; step(1); alloc_valid = 1'b0;
    ntag = (ntag + 1) % DEPTH;
  endtask

  task automatic set_addr(input int t, input logic [31:0] b, input logic [31:0] o);
    opa_valid = 1'b1; opa_tag = IW'(t); opa_base = b; opa_offset = o;
    step(1); opa_valid = 1'b0;
  endtask

  task automatic set_data(input int t, input logic [31:0] d);
    opd_valid = 1'b1; opd_tag = IW'(t); opd_value = d; step(1); opd_valid = 1'b0;
  endtask

  task automatic do_commit();
    commit_valid = 1'b1; step(1); commit_valid = 1'b0;
  endtask

  // store/load pair table: kind 0 = memory read, 1 = forward, 2 = wait then forward
  localparam int NROW = 6;
  localparam logic [31:0] T_SA [NROW] = '{32'h100, 32'h100, 32'h200, 32'h400, 32'h0000_0010, 32'h0000_0020};
  localparam logic [31:0] T_LA [NROW] = '{32'h100, 32'h104, 32'h300, 32'h400, 32'h8000_0010, 32'h0000_0020};
  localparam bit          T_GD [NROW] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam int          T_K  [NROW] = '{1, 0, 0, 2, 0, 1};
  localparam logic [31:0] T_SD [NROW] = '{32'h1111, 32'h2222, 32'h3333, 32'h4444, 32'h5555, 32'h6666};

  initial begin : main
    int s, l, mb, lb, t0, t1, t2;
    step(3);
    rst = 1'b0;
    step(1);
    // R1
    chk(alloc_full == 1'b0, "R1 full after reset", 32'(alloc_full), 0);
    chk(alloc_tag == '0, "R1 tag after reset", 32'(alloc_tag), 0);
    chk(mcnt == 0, "R1 no request after reset", mcnt, 0);
    chk(lcnt == 0, "R1 no result after reset", lcnt, 0);

    for (int r = 0; r < NROW; r++) begin
      mb = mcnt; lb = lcnt;
      do_alloc(1'b1, s); do_alloc(1'b0, l);
      set_addr(s, T_SA[r] - 32'd4, 32'd4);
      if (T_GD[r]) set_data(s, T_SD[r]);
      set_addr(l, T_LA[r] - 32'd8, 32'd8);
      step(6);
      if (T_K[r] == 0) begin
        chk(mcnt - mb == 1 && m_wr[mb & 255] == 1'b0, "R10 one read request", mcnt - mb, 1);
        chk(m_addr[mb & 255] == T_LA[r], "R3 read address base+offset", m_addr[mb & 255], T_LA[r]);
        chk(m_tag[mb & 255] == l, "R10 read tag", m_tag[mb & 255], l);
        chk(lcnt - lb == 1 && l_data[lb & 255] == memval(T_LA[r]), "R9 R10 read data", l_data[lb & 255], memval(T_LA[r]));
      end else if (T_K[r] == 1) begin
        chk(mcnt == mb, "R5 no memory request on forward", mcnt - mb, 0);
        chk(lcnt - lb == 1 && l_data[lb & 255] == T_SD[r], "R5 forwarded data", l_data[lb & 255], T_SD[r]);
        chk(l_tag[lb & 255] == l, "R5 forwarded tag", l_tag[lb & 255], l);
      end else begin
        chk(lcnt == lb && mcnt == mb, "R6 load waits for store data", lcnt - lb, 0);
        set_data(s, T_SD[r]);
        step(4);
        chk(lcnt - lb == 1 && l_data[lb & 255] == T_SD[r], "R6 data forwarded on arrival", l_data[lb & 255], T_SD[r]);
        chk(mcnt == mb, "R6 no read after wait", mcnt - mb, 0);
      end
      if (!T_GD[r] && T_K[r] != 2) set_data(s, T_SD[r]);
      do_commit(); step(4); do_commit(); step(2);
    end

    // R4: unresolved older store blocks a load to another address
    do_reset();
    mb = mcnt; lb = lcnt;
    do_alloc(1'b1, s); do_alloc(1'b0, l);
    set_addr(l, 32'h500, 32'h0);
    step(6);
    chk(mcnt == mb && lcnt == lb, "R4 load held by unknown store address", mcnt - mb, 0);
    set_addr(s, 32'h600, 32'h0);
    step(6);
    chk(mcnt - mb == 1 && m_addr[mb & 255] == 32'h500, "R4 load reads after resolve", m_addr[mb & 255], 32'h500);

    // R5: youngest older matching store supplies data
    do_reset();
    mb = mcnt; lb = lcnt;
    do_alloc(1'b1, t0); do_alloc(1'b1, t1); do_alloc(1'b0, t2);
    set_addr(t0, 32'h700, 0); set_data(t0, 32'h11);
    set_addr(t1, 32'h700, 0); set_data(t1, 32'h22);
    set_addr(t2, 32'h700, 0);
    step(6);
    chk(lcnt - lb == 1 && l_data[lb & 255] == 32'h22, "R5 youngest store wins", l_data[lb & 255], 32'h22);

    // R8: two loads released together, oldest first, one per cycle
    do_reset();
    mb = mcnt;
    do_alloc(1'b1, t0); do_alloc(1'b0, t1); do_alloc(1'b0, t2);
    set_addr(t1, 32'h800, 0); set_addr(t2, 32'h900, 0);
    set_addr(t0, 32'hA00, 0);
    step(6);
    chk(mcnt - mb == 2, "R8 two reads", mcnt - mb, 2);
    chk(m_tag[mb & 255] == t1 && m_addr[mb & 255] == 32'h800, "R8 oldest load first", m_tag[mb & 255], t1);
    chk(m_cyc[(mb + 1) & 255] == m_cyc[mb & 255] + 1, "R8 next load one cycle later",
        m_cyc[(mb + 1) & 255] - m_cyc[mb & 255], 1);

    // R7: store writes only after commit
    do_reset();
    mb = mcnt;
    do_alloc(1'b1, t0);
    set_addr(t0, 32'hB00, 0); set_data(t0, 32'hBEEF);
    step(6);
    chk(mcnt == mb, "R7 no write before commit", mcnt - mb, 0);
    do_commit(); step(4);
    chk(mcnt - mb == 1 && m_wr[mb & 255] == 1'b1, "R7 write after commit", mcnt - mb, 1);
    chk(m_addr[mb & 255] == 32'hB00 && m_data[mb & 255] == 32'hBEEF, "R7 write address and data",
        m_data[mb & 255], 32'hBEEF);

    // R2: tags in order, full, ignored allocation
    do_reset();
    for (int k = 0; k < DEPTH; k++) begin
      chk(alloc_tag == IW'(k), "R2 tag order", 32'(alloc_tag), k);
      do_alloc(1'b0, t0);
    end
    chk(alloc_full == 1'b1, "R2 full after DEPTH allocations", 32'(alloc_full), 1);
    alloc_valid = 1'b1; step(1); alloc_valid = 1'b0; step(1);
    chk(alloc_tag == '0 && alloc_full, "R2 allocation ignored when full", 32'(alloc_tag), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk + 1, nfail + 1);
    $finish;
  end
endmodule